// File: doc/BRIEF.md
# I2C Target Byte-Phase Sequencer

This block is the bus-facing half of an I2C target with one fixed 7-bit address. It samples SCL and SDA through a short synchroniser, detects START and STOP, and walks an explicit phase machine: address reception, the acknowledge slot, data reception, data transmission and the controller's acknowledge slot. It drives the bus only through two open-drain low-enables, one for SDA and one for SCL.

The handler behind it never has to meet bus timing. After every byte the controller writes, the block raises a one-cycle write strobe with the byte and its position in the transfer. It then holds SCL low until the handler answers with an accept or reject decision. Before every byte the controller reads, it raises a one-cycle read request with the byte position and holds SCL low until the handler supplies the byte. When an answer arrives, the block first sets up SDA and then lets SCL go after a short fixed settle delay. This keeps the synchronised view of SDA from moving in the same cycle as SCL, which would look like a START.

Top module: `i2cTargetFsm`

## Requirements
- R1: Coming out of reset, both bus low-enables are released and neither the write strobe nor the read request is active.
- R2: A first byte of 0x52 (address 0x29 followed by a 0 direction bit) is acknowledged by pulling SDA low for the whole acknowledge slot.
- R3: A first byte that is neither 0x52 nor 0x53 (for example 0x54) is answered with a NAK (SDA left high in the acknowledge slot). The block then ignores the bus until the next START, so later bytes produce no strobe and no acknowledge.
- R4: Each byte the controller writes produces exactly one single-cycle write strobe carrying the byte, received MSB first. The byte index is 0 for the first byte after the address and rises by 1 for each later byte.
- R5: SCL is held low from the end of each written byte until the handler's decision, and before each transmitted byte until the handler's data. The hold ends SETTLE+1 clock cycles (4 with defaults) after the cycle in which the answer is sampled.
- R6: A decision of usrAck=1 acknowledges the byte (SDA low in its slot). usrAck=0 sends a NAK, after which further written bytes are not strobed.
- R7: A first byte of 0x53 (address 0x29 followed by a 1 direction bit) is acknowledged and followed by a read request with index 0. The byte the handler returns is shifted out MSB first.
- R8: A controller ACK (SDA low) after a transmitted byte leads to a new read request with the next index. A controller NAK (SDA high) ends the transfer with no further request.
- R9: A STOP releases the bus and returns to idle from any point, including the middle of a byte, with nothing strobed. A repeated START restarts address reception, and the byte index starts again at 0.
- R10: SDA is pulled low only in acknowledge slots and in transmitted 0 bits. Its drive changes only while SCL is low, and it never pulls a written 1 bit low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL level seen on the bus |
| sdaIn | input | 1 | SDA level seen on the bus |
| sclHoldLow | output | 1 | Open-drain enable pulling SCL low (clock stretch) |
| sdaDriveLow | output | 1 | Open-drain enable pulling SDA low |
| wrStrobe | output | 1 | One-cycle pulse: a written byte is available |
| wrData | output | 8 | Byte last received from the controller |
| byteIndex | output | IDX_W | Position of the current byte in the transfer |
| usrAckValid | input | 1 | Handler presents its decision for the strobed byte |
| usrAck | input | 1 | 1 = acknowledge, 0 = NAK |
| rdReq | output | 1 | One-cycle pulse: handler must supply the next read byte |
| rdValid | input | 1 | Handler presents the byte to transmit |
| rdData | input | 8 | Byte to transmit, MSB first |

## Verification
A phase machine sitting in the wrong state shows at the ports within one byte. The acknowledge bit the controller samples flips, a strobe or request appears where none belongs, or an index is skipped or fails to restart. A miscounted edge counter shifts every later bit of a transmitted byte, so the controller reads a wrong value as soon as that byte ends. A wrong hold or settle count shows as a stretch that never ends, caught by the stalled bus, or that ends at the wrong cycle. A START or STOP seen at the wrong moment leaves SDA pulled low or an acknowledge missing on the very next slot.

// File: rtl/i2cTargetPkg.sv
package i2cTargetPkg;

  localparam int BitsPerByte = 8;
  localparam int ByteEdges   = 2 * BitsPerByte;  // a rise and a fall per bit
  localparam int AckEdges    = 2;
  localparam int EdgeCntW    = $clog2(ByteEdges + 1);

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_START_WAIT,
    PH_ADDR,
    PH_ACK_WADDR,
    PH_ACK_RADDR,
    PH_SEND_NAK,
    PH_RX_DATA,
    PH_WAIT_ACK,
    PH_ACK_RXDATA,
    PH_WAIT_RD,
    PH_TX_DATA,
    PH_RX_CTRL_ACK
  } phaseT;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadByte;
    logic loadAck;
    logic rxShiftEn;
    logic txLoad;
    logic txShiftEn;
    logic idxClr;
    logic idxInc;
  } dpCmdT;

  // Per-phase bus behaviour
  typedef struct packed {
    logic drvAck;
    logic drvTx;
    logic hold;
  } phaseFlagsT;

  function automatic phaseFlagsT phaseFlags(phaseT p);
    phaseFlagsT f;
    f = '0;
    case (p)
      PH_ACK_WADDR, PH_ACK_RADDR, PH_ACK_RXDATA: f.drvAck = 1'b1;
      PH_TX_DATA:                                f.drvTx  = 1'b1;
      PH_WAIT_ACK, PH_WAIT_RD:                   f.hold   = 1'b1;
      default:                                   f        = '0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/i2cBusSync.sv
module i2cBusSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclRaw,
  input  logic sdaRaw,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe[0] <= sclRaw;
      sdaPipe[0] <= sdaRaw;
      for (int i = 1; i < STAGES; i++) begin
        sclPipe[i] <= sclPipe[i-1];
        sdaPipe[i] <= sdaPipe[i-1];
      end
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclS      = sclPipe[STAGES-1];
  assign sdaS      = sdaPipe[STAGES-1];
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;

endmodule

// File: rtl/i2cTargetDatapath.sv
module i2cTargetDatapath
  import i2cTargetPkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmdT            cmd,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             sdaS,
  input  logic [7:0]       rdData,
  output logic [7:0]       rxByte,
  output logic             txBit,
  output logic [IDX_W-1:0] byteIdx,
  output logic             lastEdge
);

  logic [EdgeCntW-1:0] edgeCnt;
  logic [7:0]          txShift;
  logic                anyEdge;

  assign anyEdge  = sclRise | sclFall;
  assign lastEdge = anyEdge && (edgeCnt == EdgeCntW'(1));
  assign txBit    = txShift[7];

  // Edge counter, reloaded for each phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
    end else if (cmd.loadByte) begin
      edgeCnt <= EdgeCntW'(ByteEdges);
    end else if (cmd.loadAck) begin
      edgeCnt <= EdgeCntW'(AckEdges);
    end else if (anyEdge && edgeCnt != '0) begin
      edgeCnt <= edgeCnt - EdgeCntW'(1);
    end
  end

  // Receive shifter, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
    end else if (cmd.rxShiftEn) begin
      rxByte <= {rxByte[6:0], sdaS};
    end
  end

  // Transmit shifter, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
    end else if (cmd.txLoad) begin
      txShift <= rdData;
    end else if (cmd.txShiftEn) begin
      txShift <= {txShift[6:0], 1'b1};
    end
  end

  // Byte index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0;
    end else if (cmd.idxClr) begin
      byteIdx <= '0;
    end else if (cmd.idxInc) begin
      byteIdx <= byteIdx + IDX_W'(1);
    end
  end

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (byteIdx != $past(byteIdx)) |-> (byteIdx == '0 || byteIdx == $past(byteIdx) + IDX_W'(1)))
    else $error("byte index jumped"); // R4

endmodule

// File: rtl/i2cTargetControl.sv
module i2cTargetControl
  import i2cTargetPkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h29,
  parameter int         SETTLE      = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclS,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       lastEdge,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  input  logic       usrAckValid,
  input  logic       usrAck,
  input  logic       rdValid,
  output dpCmdT      cmd,
  output logic       sclHoldLow,
  output logic       sdaDriveLow,
  output logic       wrStrobe,
  output logic       rdReq
);

  localparam int         SetW     = $clog2(SETTLE + 1);
  localparam logic [7:0] WrMatch  = {TARGET_ADDR, 1'b0};
  localparam logic [7:0] RdMatch  = {TARGET_ADDR, 1'b1};

  phaseT      phase, phaseNext;
  phaseFlagsT flags;
  logic [SetW-1:0] settleCnt;
  logic leaveWait, wrNext, rdNext;

  always_comb begin
    phaseNext = phase;
    cmd       = '0;
    leaveWait = 1'b0;
    wrNext    = 1'b0;
    rdNext    = 1'b0;
    if (stopSeen) begin
      phaseNext = PH_IDLE;
    end else if (startSeen) begin
      phaseNext = PH_START_WAIT;
    end else begin
      case (phase)
        PH_IDLE: phaseNext = PH_IDLE;
        PH_START_WAIT: begin
          if (sclFall) begin
            phaseNext    = PH_ADDR;
            cmd.loadByte = 1'b1;
          end
        end
        PH_ADDR: begin
          cmd.rxShiftEn = sclRise;
          if (lastEdge) begin
            cmd.loadAck = 1'b1;
            if (rxByte == WrMatch) begin
              phaseNext  = PH_ACK_WADDR;
              cmd.idxClr = 1'b1;
            end else if (rxByte == RdMatch) begin
              phaseNext  = PH_ACK_RADDR;
              cmd.idxClr = 1'b1;
            end else begin
              phaseNext = PH_SEND_NAK;
            end
          end
        end
        PH_ACK_WADDR, PH_ACK_RXDATA: begin
          if (lastEdge) begin
            phaseNext    = PH_RX_DATA;
            cmd.loadByte = 1'b1;
          end
        end
        PH_ACK_RADDR: begin
          if (lastEdge) begin
            phaseNext = PH_WAIT_RD;
            rdNext    = 1'b1;
          end
        end
        PH_SEND_NAK: begin
          if (lastEdge) phaseNext = PH_IDLE;
        end
        PH_RX_DATA: begin
          cmd.rxShiftEn = sclRise;
          if (lastEdge) begin
            phaseNext = PH_WAIT_ACK;
            wrNext    = 1'b1;
          end
        end
        PH_WAIT_ACK: begin
          if (usrAckValid) begin
            phaseNext   = usrAck ? PH_ACK_RXDATA : PH_SEND_NAK;
            cmd.loadAck = 1'b1;
            cmd.idxInc  = 1'b1;
            leaveWait   = 1'b1;
          end
        end
        PH_WAIT_RD: begin
          if (rdValid) begin
            phaseNext    = PH_TX_DATA;
            cmd.txLoad   = 1'b1;
            cmd.loadByte = 1'b1;
            cmd.idxInc   = 1'b1;
            leaveWait    = 1'b1;
          end
        end
        PH_TX_DATA: begin
          cmd.txShiftEn = sclFall;
          if (lastEdge) begin
            phaseNext   = PH_RX_CTRL_ACK;
            cmd.loadAck = 1'b1;
          end
        end
        PH_RX_CTRL_ACK: begin
          cmd.rxShiftEn = sclRise;
          if (lastEdge) begin
            if (!rxByte[0]) begin
              phaseNext = PH_WAIT_RD;
              rdNext    = 1'b1;
            end else begin
              phaseNext = PH_IDLE;
            end
          end
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      wrStrobe  <= 1'b0;
      rdReq     <= 1'b0;
      settleCnt <= '0;
    end else begin
      phase    <= phaseNext;
      wrStrobe <= wrNext;
      rdReq    <= rdNext;
      if (stopSeen) begin
        settleCnt <= '0;
      end else if (leaveWait) begin
        settleCnt <= SetW'(SETTLE);
      end else if (settleCnt != '0) begin
        settleCnt <= settleCnt - SetW'(1);
      end
    end
  end

  assign flags       = phaseFlags(phase);
  assign sclHoldLow  = flags.hold | (settleCnt != '0);
  assign sdaDriveLow = flags.drvAck | (flags.drvTx & ~txBit);

  AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    sclHoldLow |-> !sclS)
    else $error("stretch while SCL seen high"); // R5

  AST_SDA_EDGE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDriveLow != $past(sdaDriveLow)) |-> !sclS)
    else $error("SDA drive moved while SCL high"); // R10

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe)
    else $error("write strobe longer than one cycle"); // R4

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq)
    else $error("read request longer than one cycle"); // R7

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (!sclHoldLow && !sdaDriveLow))
    else $error("bus not released after STOP"); // R9

endmodule

// File: rtl/i2cTargetFsm.sv
module i2cTargetFsm
  import i2cTargetPkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h29,
  parameter int         IDX_W       = 8,
  parameter int         SETTLE      = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclHoldLow,
  output logic             sdaDriveLow,
  output logic             wrStrobe,
  output logic [7:0]       wrData,
  output logic [IDX_W-1:0] byteIndex,
  input  logic             usrAckValid,
  input  logic             usrAck,
  output logic             rdReq,
  input  logic             rdValid,
  input  logic [7:0]       rdData
);

  logic  sclS, sdaS, sclRise, sclFall, startSeen, stopSeen;
  logic  lastEdge, txBit;
  logic [7:0] rxByte;
  dpCmdT cmd;

  i2cBusSync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .sclRaw(sclIn), .sdaRaw(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  i2cTargetControl #(.TARGET_ADDR(TARGET_ADDR), .SETTLE(SETTLE)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .lastEdge(lastEdge),
    .rxByte(rxByte), .txBit(txBit), .usrAckValid(usrAckValid), .usrAck(usrAck),
    .rdValid(rdValid), .cmd(cmd), .sclHoldLow(sclHoldLow),
    .sdaDriveLow(sdaDriveLow), .wrStrobe(wrStrobe), .rdReq(rdReq)
  );

  i2cTargetDatapath #(.IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sclRise(sclRise), .sclFall(sclFall),
    .sdaS(sdaS), .rdData(rdData), .rxByte(rxByte), .txBit(txBit),
    .byteIdx(byteIndex), .lastEdge(lastEdge)
  );

  assign wrData = rxByte;

endmodule

// File: tb/i2cTargetFsm_tb_top.sv
module i2cTargetFsm_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;   // clocks per quarter bit
  localparam int HOLD_LAT   = 4;   // SETTLE+1 with defaults

  typedef struct {
    bit         isRead;
    logic [7:0] idx;
    logic [7:0] data;
    logic       ack;
    string      req;
  } itemT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclCtl = 1'b1, sdaCtl = 1'b1;
  logic sclHoldLow, sdaDriveLow, wrStrobe, rdReq;
  logic [7:0] wrData, byteIndex, rdData;
  logic usrAckValid, usrAck, rdValid;
  wire  sclBus = sclCtl & ~sclHoldLow;
  wire  sdaBus = sdaCtl & ~sdaDriveLow;

  int checks = 0, errors = 0, unexp = 0;
  bit done = 0;
  string curReq = "R1";
  itemT expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cTargetFsm dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus),
    .sclHoldLow(sclHoldLow), .sdaDriveLow(sdaDriveLow),
    .wrStrobe(wrStrobe), .wrData(wrData), .byteIndex(byteIndex),
    .usrAckValid(usrAckValid), .usrAck(usrAck),
    .rdReq(rdReq), .rdValid(rdValid), .rdData(rdData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- driver side ----------------
  task automatic pushItem(input bit rd, input logic [7:0] idx,
                          input logic [7:0] data, input logic ack, input string req);
    itemT it;
    it.isRead = rd; it.idx = idx; it.data = data; it.ack = ack; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic clockBit(input logic drv, output logic smp);
    waitQ();
    sdaCtl = drv;
    waitQ();
    sclCtl = 1'b1;
    @(negedge clk);
    while (!sclBus) @(negedge clk);
    waitQ();
    smp = sdaBus;
    waitQ();
    sclCtl = 1'b0;
  endtask

  task automatic startCond();
    sdaCtl = 1'b1;
    waitQ();
    sclCtl = 1'b1;
    @(negedge clk);
    while (!sclBus) @(negedge clk);
    waitQ();
    sdaCtl = 1'b0;
    waitQ();
    sclCtl = 1'b0;
  endtask

  task automatic stopCond();
    waitQ();
    sdaCtl = 1'b0;
    waitQ();
    sclCtl = 1'b1;
    @(negedge clk);
    while (!sclBus) @(negedge clk);
    waitQ();
    sdaCtl = 1'b1;
    waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack, output bit hiOk);
    logic s;
    hiOk = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      clockBit(b[i], s);
      if (b[i] && !s) hiOk = 1'b0;
    end
    clockBit(1'b1, ack);
  endtask

  task automatic recvByte(input logic nak, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clockBit(1'b1, s);
      d = {d[6:0], s};
    end
    clockBit(nak, s);
  endtask

  // ---------------- monitor / responder ----------------
  initial begin
    itemT it;
    int k;
    usrAckValid = 1'b0; usrAck = 1'b0; rdValid = 1'b0; rdData = '0;
    forever begin
      @(negedge clk);
      if (wrStrobe || rdReq) begin
        if (expQ.size() == 0) begin
          unexp++;
          chk(1'b0, curReq, "unexpected strobe/request", {wrStrobe, rdReq}, 0);
          it.isRead = rdReq; it.idx = '0; it.data = 8'hFF; it.ack = 1'b0; it.req = curReq;
        end else begin
          it = expQ.pop_front();
          if (it.isRead) begin
            chk(rdReq && !wrStrobe, it.req, "read request expected", {wrStrobe, rdReq}, 1);
            chk(byteIndex == it.idx, it.req, "read index", byteIndex, it.idx);
          end else begin
            chk(wrStrobe && !rdReq, it.req, "write strobe expected", {wrStrobe, rdReq}, 2);
            chk(wrData == it.data, "R4", "write data", wrData, it.data);
            chk(byteIndex == it.idx, "R4", "write index", byteIndex, it.idx);
          end
        end
        repeat (2) @(negedge clk);
        chk(sclHoldLow, "R5", "SCL hold while waiting", sclHoldLow, 1);
        if (it.isRead) begin rdValid = 1'b1; rdData = it.data; end
        else begin usrAckValid = 1'b1; usrAck = it.ack; end
        @(negedge clk);
        rdValid = 1'b0; usrAckValid = 1'b0;
        k = 1;
        while (sclHoldLow && k < 20) begin
          @(negedge clk);
          k++;
        end
        chk(k == HOLD_LAT, "R5", "hold release latency", k, HOLD_LAT);
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired in %s actual=0 expected=1", curReq);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic a, s;
    bit hiOk;
    logic [7:0] d;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!sdaDriveLow && !sclHoldLow, "R1", "bus released after reset",
        {sdaDriveLow, sclHoldLow}, 0);
    chk(!wrStrobe && !rdReq, "R1", "no strobes after reset", {wrStrobe, rdReq}, 0);

    // Write transfer of three bytes
    curReq = "R4";
    startCond();
    sendByte(8'h52, a, hiOk);
    chk(a == 1'b0, "R2", "write address ack", a, 0);
    pushItem(0, 8'd0, 8'hA5, 1'b1, "R4");
    sendByte(8'hA5, a, hiOk);
    chk(a == 1'b0, "R6", "accepted byte acked", a, 0);
    chk(hiOk, "R10", "written 1 bits stay high", hiOk, 1);
    pushItem(0, 8'd1, 8'h3C, 1'b1, "R4");
    sendByte(8'h3C, a, hiOk);
    chk(a == 1'b0, "R4", "second byte acked", a, 0);
    pushItem(0, 8'd2, 8'h81, 1'b1, "R4");
    sendByte(8'h81, a, hiOk);
    chk(hiOk, "R10", "written 1 bits stay high", hiOk, 1);
    stopCond();
    chk(expQ.size() == 0, "R4", "all writes strobed", expQ.size(), 0);
    chk(!sdaDriveLow, "R10", "SDA released when idle", sdaDriveLow, 0);

    // Address mismatch
    curReq = "R3";
    startCond();
    sendByte(8'h54, a, hiOk);
    chk(a == 1'b1, "R3", "foreign address NAK", a, 1);
    sendByte(8'h00, a, hiOk);
    chk(a == 1'b1, "R3", "byte after NAK not acked", a, 1);
    stopCond();
    chk(unexp == 0, "R3", "no strobe after mismatch", unexp, 0);

    // Handler NAK
    curReq = "R6";
    startCond();
    sendByte(8'h52, a, hiOk);
    chk(a == 1'b0, "R2", "write address ack", a, 0);
    pushItem(0, 8'd0, 8'h77, 1'b0, "R6");
    sendByte(8'h77, a, hiOk);
    chk(a == 1'b1, "R6", "rejected byte NAKed", a, 1);
    sendByte(8'h88, a, hiOk);
    chk(a == 1'b1, "R6", "byte after NAK ignored", a, 1);
    stopCond();
    chk(unexp == 0 && expQ.size() == 0, "R6", "no strobe after NAK", unexp, 0);

    // Read transfer
    curReq = "R8";
    startCond();
    sendByte(8'h53, a, hiOk);
    chk(a == 1'b0, "R7", "read address ack", a, 0);
    pushItem(1, 8'd0, 8'hC3, 1'b1, "R7");
    recvByte(1'b0, d);
    chk(d == 8'hC3, "R7", "first read byte", d, 8'hC3);
    pushItem(1, 8'd1, 8'h5A, 1'b1, "R8");
    recvByte(1'b0, d);
    chk(d == 8'h5A, "R8", "second read byte", d, 8'h5A);
    pushItem(1, 8'd2, 8'h01, 1'b1, "R8");
    recvByte(1'b1, d);
    chk(d == 8'h01, "R8", "last read byte", d, 8'h01);
    repeat (40) @(negedge clk);
    chk(unexp == 0 && !sclHoldLow, "R8", "no request after controller NAK", unexp, 0);
    stopCond();

    // Repeated START: write then read, index restarts
    curReq = "R9";
    startCond();
    sendByte(8'h52, a, hiOk);
    pushItem(0, 8'd0, 8'h10, 1'b1, "R9");
    sendByte(8'h10, a, hiOk);
    chk(a == 1'b0, "R9", "byte before repeated START acked", a, 0);
    startCond();
    sendByte(8'h53, a, hiOk);
    chk(a == 1'b0, "R9", "read address after repeated START", a, 0);
    pushItem(1, 8'd0, 8'h99, 1'b1, "R9");
    recvByte(1'b1, d);
    chk(d == 8'h99, "R9", "read after repeated START", d, 8'h99);
    stopCond();

    // STOP in the middle of a byte
    startCond();
    sendByte(8'h52, a, hiOk);
    clockBit(1'b1, s);
    clockBit(1'b0, s);
    clockBit(1'b1, s);
    stopCond();
    repeat (10) @(negedge clk);
    chk(!sclHoldLow && !sdaDriveLow, "R9", "bus released after mid-byte STOP",
        {sclHoldLow, sdaDriveLow}, 0);
    chk(unexp == 0 && expQ.size() == 0, "R9", "nothing strobed on partial byte", unexp, 0);
    startCond();
    sendByte(8'h52, a, hiOk);
    chk(a == 1'b0, "R9", "address after mid-byte STOP", a, 0);
    pushItem(0, 8'd0, 8'h42, 1'b1, "R9");
    sendByte(8'h42, a, hiOk);
    chk(a == 1'b0, "R9", "fresh transfer byte acked", a, 0);
    stopCond();
    repeat (10) @(negedge clk);
    chk(expQ.size() == 0, "R9", "fresh transfer strobed", expQ.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule